// File: doc/BRIEF.md
# Read/Write Grouping Bank Request Selector

This block sits in a DRAM controller between the request intake and the command issue stage. Requests enter per-bank in-order queues, each entry tagged as a read or a write with a row and a column. A single mode bit shared by every bank decides whether reads or writes are served. The mode stays put until every queue in the block has run out of the current type, so the data bus changes direction less often. Fewer direction changes also means fewer write-to-read turnaround penalties.

The issue stage asks about one bank at a time and receives a command kind and a queue position. It is told to issue a column access when the chosen request hits the open row of that bank. Otherwise it is told to issue a row command and must open the right row itself. A read that would overtake an older write to the same row and column is held back: the mode is forced to write so that the older write goes first. Timing, refresh, data and the choice between activate and precharge all stay outside the block.

Top module: `rw_group_sched`

## Requirements
- R1: After reset the block is in read mode (`rd_mode`=1), every queue is empty, `bank_full` is all zero, `qry_ready` is 1 and `rsp_valid` is 0.
- R2: `enq_ready` is 1 exactly when the queue of `enq_bank` holds fewer than DEPTH entries, and `bank_full` bit b is 1 exactly when queue b holds DEPTH entries. A refused request is not stored and is never served.
- R3: A query of an empty bank answers `rsp_cmd`=0 (no operation) with `rsp_idx`=0 and leaves the mode unchanged.
- R4: When a query of a non-empty bank begins, the mode flips to write if no read is queued in any bank, and flips to read if it is in write mode and no write is queued in any bank.
- R5: In read mode the oldest read of the bank is chosen. If the bank's open-row flag is set and its row equals the open row, the answer is `rsp_cmd`=1 and the entry leaves the queue. Otherwise the answer is `rsp_cmd`=3 (row command) and the entry stays queued.
- R6: In write mode the oldest write of the bank is chosen. A hit answers `rsp_cmd`=2 and removes the entry, and a miss answers 3 and keeps it. Older reads to the same address do not hold a write back.
- R7: If any entry older than the chosen read is a write with the same row and column, the mode is forced to write and the selection is repeated once in write mode.
- R8: If the bank holds no request of the current type, the global mode toggles and the selection is repeated once for the same bank. If that second pass finds nothing either, the answer is 0.
- R9: A query is accepted on a clock edge where `qry_valid` and `qry_ready` are both 1. `qry_ready` stays 0 until the response. `rsp_valid` is a one-cycle pulse that rises on the first edge after acceptance when one pass suffices, and on the second edge when a selection is repeated.
- R10: `rsp_idx` is the position of the chosen entry counted from the oldest entry (0). After an entry is removed, the entries behind it keep their relative order and each moves up by one position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Queue of `enq_bank` can take the request |
| enq_bank | input | $clog2(NBANKS) | Target bank of the new request |
| enq_is_wr | input | 1 | 1 for a write, 0 for a read |
| enq_row | input | ROW_W | Row of the new request |
| enq_col | input | COL_W | Column of the new request |
| bank_full | output | NBANKS | Per-bank queue full flags |
| open_vld | input | NBANKS | Per-bank flag: a row is open |
| open_rows | input | NBANKS*ROW_W | Open row of each bank, bank b at bits b*ROW_W upward |
| qry_valid | input | 1 | Bank query offered |
| qry_ready | output | 1 | Selector is idle and takes a query |
| qry_bank | input | $clog2(NBANKS) | Bank being queried |
| rsp_valid | output | 1 | Response pulse |
| rsp_cmd | output | 2 | 0 none, 1 column read, 2 column write, 3 row command |
| rsp_idx | output | $clog2(DEPTH) | Queue position of the chosen entry |
| rd_mode | output | 1 | Global mode, 1 = read |

## Verification
The hardest situation to reach is the read-after-write hazard. It needs a read-mode query on a bank whose oldest read sits behind a write to the same row and column, while reads remain elsewhere so the mode has not already flipped. The bench builds it on purpose: it first serves a read-only bank to put the block into read mode, then queries the bank holding the colliding pair. It also sweeps every read/write mix of a full queue with row and column values chosen to collide now and then. Each sweep is drained against a bench-side queue model, and after every row command the bench opens the requested row so that each entry is finally served.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_ROW = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_P1   = 2'd1,
    ST_P2   = 2'd2
  } st_e;
endpackage

// File: rtl/rwg_bank_queue.sv
// In-order request queue of one bank with removal from any position.
module rwg_bank_queue #(
  parameter int DEPTH = 4,
  parameter int EW    = 15,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic [EW-1:0]       push_data_i,
  input  logic                pop_i,
  input  logic [IW-1:0]       pop_idx_i,
  output logic [DEPTH*EW-1:0] slots_o,
  output logic [CW-1:0]       count_o,
  output logic                full_o
);
  logic [DEPTH*EW-1:0] slots_q, slots_n;
  logic [CW-1:0]       count_q, count_n;
  logic                upd_en;

  assign upd_en = push_i | pop_i;

  always_comb begin
    slots_n = slots_q;
    count_n = count_q;
    if (pop_i) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        if (IW'(k) >= pop_idx_i) begin
          slots_n[k*EW +: EW] = slots_q[(k+1)*EW +: EW];
        end
      end
      count_n = count_n - CW'(1);
    end
    if (push_i) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (CW'(k) == count_n) begin
          slots_n[k*EW +: EW] = push_data_i;
        end
      end
      count_n = count_n + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (upd_en) begin
      count_q <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      slots_q <= slots_n;
    end
  end

  assign slots_o = slots_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));
endmodule

// File: rtl/rwg_picker.sv
// Finds the oldest entry of the wanted type, its row hit and the read hazard.
module rwg_picker #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int EW   = 1 + ROW_W + COL_W,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH*EW-1:0] slots_i,
  input  logic [CW-1:0]       count_i,
  input  logic                want_wr_i,
  input  logic                open_vld_i,
  input  logic [ROW_W-1:0]    open_row_i,
  output logic                found_o,
  output logic [IW-1:0]       sel_o,
  output logic                row_hit_o,
  output logic                hazard_o
);
  logic [EW-1:0]    pick;
  logic [ROW_W-1:0] pick_row;
  logic [COL_W-1:0] pick_col;
  logic             clash;

  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if ((CW'(k) < count_i) && (slots_i[k*EW + EW - 1] == want_wr_i)) begin
        found_o = 1'b1;
        sel_o   = IW'(k);
      end
    end
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (IW'(k) == sel_o) begin
        pick = slots_i[k*EW +: EW];
      end
    end
  end

  assign pick_row = pick[COL_W +: ROW_W];
  assign pick_col = pick[0 +: COL_W];

  always_comb begin
    clash = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((IW'(k) < sel_o) && slots_i[k*EW + EW - 1] &&
          (slots_i[k*EW + COL_W +: ROW_W] == pick_row) &&
          (slots_i[k*EW +: COL_W] == pick_col)) begin
        clash = 1'b1;
      end
    end
  end

  assign row_hit_o = open_vld_i && (pick_row == open_row_i);
  assign hazard_o  = clash && found_o && !want_wr_i;
endmodule

// File: rtl/rwg_type_count.sv
// Running totals of queued reads and writes over all banks.
module rwg_type_count #(
  parameter int TOT = 16,
  localparam int TW = $clog2(TOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_rd_i,
  input  logic          inc_wr_i,
  input  logic          dec_rd_i,
  input  logic          dec_wr_i,
  output logic [TW-1:0] rd_cnt_o,
  output logic [TW-1:0] wr_cnt_o
);
  logic [TW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic          cnt_en;

  assign cnt_en = inc_rd_i | inc_wr_i | dec_rd_i | dec_wr_i;

  always_comb begin
    rd_n = rd_q + TW'(inc_rd_i) - TW'(dec_rd_i);
    wr_n = wr_q + TW'(inc_wr_i) - TW'(dec_wr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else if (cnt_en) begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  assign rd_cnt_o = rd_q;
  assign wr_cnt_o = wr_q;
endmodule

// File: rtl/rw_group_sched.sv
module rw_group_sched
  import rwg_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int DEPTH  = 4,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  localparam int BW    = $clog2(NBANKS),
  localparam int EW    = 1 + ROW_W + COL_W,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = $clog2(DEPTH),
  localparam int TOT   = NBANKS * DEPTH,
  localparam int TW    = $clog2(TOT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enq_valid,
  output logic                    enq_ready,
  input  logic [BW-1:0]           enq_bank,
  input  logic                    enq_is_wr,
  input  logic [ROW_W-1:0]        enq_row,
  input  logic [COL_W-1:0]        enq_col,
  output logic [NBANKS-1:0]       bank_full,
  input  logic [NBANKS-1:0]       open_vld,
  input  logic [NBANKS*ROW_W-1:0] open_rows,
  input  logic                    qry_valid,
  output logic                    qry_ready,
  input  logic [BW-1:0]           qry_bank,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_cmd,
  output logic [IW-1:0]           rsp_idx,
  output logic                    rd_mode
);
  logic [DEPTH*EW-1:0] slots_w [NBANKS];
  logic [CW-1:0]       cnt_w   [NBANKS];
  logic [NBANKS-1:0]   full_w;
  logic                enq_go;
  logic                pop_go;

  st_e           state_q, state_n;
  logic          mode_q, mode_n;
  logic [BW-1:0] bank_q, bank_n;
  logic          rsp_valid_q, rsp_valid_n;
  cmd_e          rsp_cmd_q, rsp_cmd_n;
  logic [IW-1:0] rsp_idx_q, rsp_idx_n;

  logic [DEPTH*EW-1:0] cur_slots;
  logic [CW-1:0]       cur_cnt;
  logic                cur_open_vld;
  logic [ROW_W-1:0]    cur_open_row;
  logic                pass_rd;
  logic                found, row_hit, hazard;
  logic [IW-1:0]       sel_idx;
  logic [TW-1:0]       rd_cnt, wr_cnt;

  assign enq_ready = !full_w[enq_bank];
  assign enq_go    = enq_valid && enq_ready;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    rwg_bank_queue #(.DEPTH(DEPTH), .EW(EW)) q_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (enq_go && (enq_bank == BW'(b))),
      .push_data_i({enq_is_wr, enq_row, enq_col}),
      .pop_i      (pop_go && (bank_q == BW'(b))),
      .pop_idx_i  (sel_idx),
      .slots_o    (slots_w[b]),
      .count_o    (cnt_w[b]),
      .full_o     (full_w[b])
    );
  end

  always_comb begin
    cur_slots    = '0;
    cur_cnt      = '0;
    cur_open_vld = 1'b0;
    cur_open_row = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (BW'(b) == bank_q) begin
        cur_slots    = slots_w[b];
        cur_cnt      = cnt_w[b];
        cur_open_vld = open_vld[b];
        cur_open_row = open_rows[b*ROW_W +: ROW_W];
      end
    end
  end

  // Mode used by the current pass: the first pass may flip on a global drain.
  always_comb begin
    pass_rd = mode_q;
    if (state_q == ST_P1) begin
      if (mode_q && (rd_cnt == '0)) begin
        pass_rd = 1'b0;
      end else if (!mode_q && (wr_cnt == '0)) begin
        pass_rd = 1'b1;
      end
    end
  end

  rwg_picker #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) pick_i (
    .slots_i   (cur_slots),
    .count_i   (cur_cnt),
    .want_wr_i (!pass_rd),
    .open_vld_i(cur_open_vld),
    .open_row_i(cur_open_row),
    .found_o   (found),
    .sel_o     (sel_idx),
    .row_hit_o (row_hit),
    .hazard_o  (hazard)
  );

  rwg_type_count #(.TOT(TOT)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_rd_i(enq_go && !enq_is_wr),
    .inc_wr_i(enq_go && enq_is_wr),
    .dec_rd_i(pop_go && pass_rd),
    .dec_wr_i(pop_go && !pass_rd),
    .rd_cnt_o(rd_cnt),
    .wr_cnt_o(wr_cnt)
  );

  always_comb begin
    state_n     = state_q;
    mode_n      = mode_q;
    bank_n      = bank_q;
    rsp_valid_n = 1'b0;
    rsp_cmd_n   = CMD_NOP;
    rsp_idx_n   = '0;
    pop_go      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (qry_valid) begin
          bank_n  = qry_bank;
          state_n = ST_P1;
        end
      end
      ST_P1, ST_P2: begin
        if ((state_q == ST_P1) && (cur_cnt == '0)) begin
          rsp_valid_n = 1'b1;
          state_n     = ST_IDLE;
        end else if (found && !hazard) begin
          mode_n      = pass_rd;
          rsp_valid_n = 1'b1;
          rsp_idx_n   = sel_idx;
          pop_go      = row_hit;
          if (row_hit) begin
            rsp_cmd_n = pass_rd ? CMD_RD : CMD_WR;
          end else begin
            rsp_cmd_n = CMD_ROW;
          end
          state_n = ST_IDLE;
        end else if (state_q == ST_P1) begin
          mode_n  = hazard ? 1'b0 : !pass_rd;
          state_n = ST_P2;
        end else begin
          mode_n      = pass_rd;
          rsp_valid_n = 1'b1;
          state_n     = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= 1'b1;
      bank_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_cmd_q   <= CMD_NOP;
      rsp_idx_q   <= '0;
    end else begin
      state_q     <= state_n;
      mode_q      <= mode_n;
      rsp_valid_q <= rsp_valid_n;
      rsp_cmd_q   <= rsp_cmd_n;
      rsp_idx_q   <= rsp_idx_n;
      if (state_q == ST_IDLE) begin
        bank_q <= bank_n;
      end
    end
  end

  assign qry_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_cmd   = rsp_cmd_q;
  assign rsp_idx   = rsp_idx_q;
  assign rd_mode   = mode_q;
  assign bank_full = full_w;
endmodule

// File: rtl/rwg_sched_checker.sv
module rwg_sched_checker #(
  parameter int NBANKS = 4,
  parameter int DEPTH  = 4,
  parameter int BW     = 2,
  parameter int TW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enq_valid,
  input logic [BW-1:0]     enq_bank,
  input logic [NBANKS-1:0] bank_full,
  input logic              qry_valid,
  input logic              qry_ready,
  input logic              rsp_valid,
  input logic              rd_mode,
  input logic [TW-1:0]     rd_cnt,
  input logic [TW-1:0]     wr_cnt
);
  localparam int CAP = NBANKS * DEPTH;
  logic [TW:0] total;
  assign total = {1'b0, rd_cnt} + {1'b0, wr_cnt};

  // R2: a request offered to a full bank never raises the queued total.
  p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid && bank_full[enq_bank] |=> total <= $past(total));

  // R2: the queued total never exceeds the storage.
  p_total_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    total <= (TW+1)'(CAP));

  // R4: the mode moves only while a query is being worked on.
  p_mode_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode != $past(rd_mode)) |-> !$past(qry_ready));

  // R9: accepting a query makes the block busy with no response yet.
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid && qry_ready |=> !qry_ready && !rsp_valid);

  // R9: the response is a single-cycle pulse.
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind rw_group_sched rwg_sched_checker #(
  .NBANKS(NBANKS), .DEPTH(DEPTH), .BW(BW), .TW(TW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .enq_valid(enq_valid),
  .enq_bank (enq_bank),
  .bank_full(bank_full),
  .qry_valid(qry_valid),
  .qry_ready(qry_ready),
  .rsp_valid(rsp_valid),
  .rd_mode  (rd_mode),
  .rd_cnt   (rd_cnt),
  .wr_cnt   (wr_cnt)
);

// File: tb/rw_group_sched_tb_top.sv
`timescale 1ns/1ps
module rw_group_sched_tb_top;
  localparam int NB = 2;
  localparam int DP = 4;
  localparam int RW = 4;
  localparam int CL = 4;
  localparam int IW = $clog2(DP);

  logic clk = 1'b0;
  logic rst_n;
  logic enq_valid, enq_ready, enq_is_wr;
  logic [0:0] enq_bank, qry_bank;
  logic [RW-1:0] enq_row;
  logic [CL-1:0] enq_col;
  logic [NB-1:0] bank_full, open_vld;
  logic [NB*RW-1:0] open_rows;
  logic qry_valid, qry_ready, rsp_valid, rd_mode;
  logic [1:0] rsp_cmd;
  logic [IW-1:0] rsp_idx;

  always #2.5 clk = ~clk;

  rw_group_sched #(.NBANKS(NB), .DEPTH(DP), .ROW_W(RW), .COL_W(CL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_bank(enq_bank),
    .enq_is_wr(enq_is_wr), .enq_row(enq_row), .enq_col(enq_col),
    .bank_full(bank_full), .open_vld(open_vld), .open_rows(open_rows),
    .qry_valid(qry_valid), .qry_ready(qry_ready), .qry_bank(qry_bank),
    .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_idx(rsp_idx),
    .rd_mode(rd_mode)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  // Bench-side queue model built from the requirements.
  bit m_wr  [NB][DP];
  int m_row [NB][DP];
  int m_col [NB][DP];
  int m_cnt [NB];
  bit m_rd;
  bit ov    [NB];
  int orow  [NB];

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_open(int b, bit v, int row);
    ov[b] = v;
    orow[b] = row;
    open_vld[b] = v;
    open_rows[b*RW +: RW] = RW'(row);
  endtask

  task automatic m_remove(int b, int i);
    for (int k = i; k < m_cnt[b] - 1; k++) begin
      m_wr[b][k] = m_wr[b][k+1];
      m_row[b][k] = m_row[b][k+1];
      m_col[b][k] = m_col[b][k+1];
    end
    m_cnt[b]--;
  endtask

  task automatic model_query(int b, output int cmd, output int idx, output int passes);
    int tr, tw, sel;
    bit rd, hz, hit;
    cmd = 0; idx = 0; passes = 1;
    if (m_cnt[b] == 0) return;
    tr = 0; tw = 0;
    for (int x = 0; x < NB; x++)
      for (int k = 0; k < m_cnt[x]; k++)
        if (m_wr[x][k]) tw++; else tr++;
    rd = m_rd;
    if (rd && tr == 0) rd = 0;
    else if (!rd && tw == 0) rd = 1;
    for (int p = 0; p < 2; p++) begin
      passes = p + 1;
      sel = -1;
      for (int k = m_cnt[b] - 1; k >= 0; k--)
        if (m_wr[b][k] == !rd) sel = k;
      hz = 0;
      if (sel >= 0 && rd)
        for (int j = 0; j < sel; j++)
          if (m_wr[b][j] && m_row[b][j] == m_row[b][sel] && m_col[b][j] == m_col[b][sel]) hz = 1;
      if (sel >= 0 && !hz) begin
        m_rd = rd;
        hit = ov[b] && (orow[b] == m_row[b][sel]);
        cmd = hit ? (rd ? 1 : 2) : 3;
        idx = sel;
        if (hit) m_remove(b, sel);
        return;
      end
      if (p == 0) rd = hz ? 1'b0 : !rd;
    end
    m_rd = rd;
  endtask

  task automatic enq(int b, bit wr, int row, int col);
    bit exp_rdy;
    @(negedge clk);
    enq_valid = 1'b1; enq_bank = 1'(b); enq_is_wr = wr;
    enq_row = RW'(row); enq_col = CL'(col);
    exp_rdy = (m_cnt[b] < DP);
    #1;
    chk(enq_ready == exp_rdy, "R2 enq_ready", int'(enq_ready), int'(exp_rdy));
    chk(bank_full[b] == !exp_rdy, "R2 bank_full", int'(bank_full[b]), int'(!exp_rdy));
    @(posedge clk);
    #1 enq_valid = 1'b0;
    if (exp_rdy) begin
      m_wr[b][m_cnt[b]] = wr; m_row[b][m_cnt[b]] = row; m_col[b][m_cnt[b]] = col;
      m_cnt[b]++;
    end
  endtask

  task automatic query(int b, string tag, output int cmd);
    int ecmd, eidx, epass, lat;
    model_query(b, ecmd, eidx, epass);
    @(negedge clk);
    qry_valid = 1'b1; qry_bank = 1'(b);
    #1;
    chk(qry_ready == 1'b1, "R9 qry_ready idle", int'(qry_ready), 1);
    @(posedge clk);
    #1 qry_valid = 1'b0;
    lat = 0;
    for (int e = 1; e <= 3; e++) begin
      @(posedge clk);
      #1;
      if (rsp_valid) begin lat = e; break; end
      chk(qry_ready == 1'b0, "R9 busy", int'(qry_ready), 0);
    end
    chk(lat == epass, "R9 latency", lat, epass);
    chk(int'(rsp_cmd) == ecmd, {tag, " cmd"}, int'(rsp_cmd), ecmd);
    chk(int'(rsp_idx) == eidx, {tag, " R10 idx"}, int'(rsp_idx), eidx);
    chk(rd_mode == m_rd, {tag, " R4 mode"}, int'(rd_mode), int'(m_rd));
    if (ecmd == 3) set_open(b, 1'b1, m_row[b][eidx]);
    cmd = ecmd;
  endtask

  task automatic drain(string tag);
    int c, b;
    b = 0;
    for (int it = 0; it < 80; it++) begin
      if (m_cnt[0] == 0 && m_cnt[1] == 0) break;
      if (m_cnt[b] == 0) b = 1 - b;
      query(b, tag, c);
      if (c == 3) query(b, tag, c);
      b = 1 - b;
    end
    for (int x = 0; x < NB; x++) begin
      query(x, "R3 drained", c);
      chk(m_cnt[x] == 0, "R2 drained", m_cnt[x], 0);
    end
  endtask

  initial begin
    int c;
    bit mode_before;
    rst_n = 1'b0; enq_valid = 1'b0; enq_bank = '0; enq_is_wr = 1'b0;
    enq_row = '0; enq_col = '0; qry_valid = 1'b0; qry_bank = '0;
    open_vld = '0; open_rows = '0;
    m_rd = 1'b1;
    for (int x = 0; x < NB; x++) begin m_cnt[x] = 0; ov[x] = 0; orow[x] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(qry_ready == 1'b1, "R1 qry_ready", int'(qry_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(rd_mode == 1'b1, "R1 rd_mode", int'(rd_mode), 1);
    chk(bank_full == '0, "R1 bank_full", int'(bank_full), 0);

    // R3: empty bank answers no-op and keeps read mode.
    mode_before = m_rd;
    query(0, "R3 empty", c);
    chk(rd_mode == mode_before, "R3 mode kept", int'(rd_mode), int'(mode_before));

    // R2: fill bank 0 with writes, one more is refused; R4 flip to write.
    for (int k = 0; k < DP + 1; k++) enq(0, 1'b1, k, k);
    drain("R2 R4 R6 write only");

    // R7: hazard, mode first forced to read through bank 1.
    enq(0, 1'b1, 1, 2);
    enq(0, 1'b0, 1, 2);
    enq(1, 1'b0, 3, 0);
    set_open(0, 1'b1, 1);
    query(1, "R8 toggle to read", c);
    query(0, "R7 hazard", c);
    drain("R7 drain");

    // R10: removal from the middle keeps order.
    set_open(0, 1'b1, 2);
    enq(0, 1'b0, 2, 0);
    enq(0, 1'b1, 2, 1);
    enq(0, 1'b0, 3, 2);
    enq(1, 1'b1, 0, 0);
    drain("R10 middle");

    // Sweep of all read/write mixes of a full bank-0 queue.
    for (int pat = 0; pat < 16; pat++) begin
      set_open(0, 1'b0, 0);
      set_open(1, 1'b0, 0);
      for (int k = 0; k < DP; k++) enq(0, pat[k], (k + pat) % 3, (k >> 1) & 1);
      for (int k = 0; k < 2; k++) enq(1, !pat[k], k, 0);
      drain("R5 R6 R7 R8 sweep");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule